// File: doc/BRIEF.md
# Nanosecond Time-of-Day Counter

This block keeps the time of day for a 125 MHz clock domain. It holds a nanoseconds field that wraps once per second and a three-bit seconds field that counts modulo 8. Every clock cycle the time advances by a signed increment in nanoseconds. A neighbouring rate and offset correction unit supplies that increment, and its nominal value is 8. Extending the seconds count beyond three bits is left to software. Software can do this because the nanoseconds field always falls back below its previous value once per second.

Software reads the time through a snapshot. A command strobe that carries the snapshot bit freezes the whole time value into a holding register. A single 16-bit data port then returns that frozen sample as five words, one per read strobe, so every word belongs to the same instant. Software sets the time by writing five 16-bit words to a single load port. The new value takes effect all at once on the fifth word.

Top module: `tod_counter`

## Requirements
- R1: After reset the time is zero (nanoseconds 0, seconds 0), the snapshot holds zero, and the snapshot port is at word 0.
- R2: Each cycle with no load and no wrap, the nanoseconds field becomes its previous value plus the signed increment `inc_ns`.
- R3: When the previous value plus the increment reaches or exceeds NS_PER_SEC, the nanoseconds field becomes that sum minus NS_PER_SEC and the seconds field increments modulo 8 (7 goes to 0).
- R4: When the previous value plus a negative increment falls below zero, the nanoseconds field becomes that sum plus NS_PER_SEC and the seconds field decrements modulo 8 (0 goes to 7).
- R5: A cycle with `cmd_wr` and `cmd_snap` both high latches the time shown on `tod_ns`/`tod_sec` in that cycle. Later advances of the counter do not change the words read back.
- R6: `snap_data` shows the word at the current read index. Word 0 and word 1 are zero, word 2 is the seconds in bits 2:0 with zeros above, word 3 is nanoseconds bits 31:16, and word 4 is nanoseconds bits 15:0. Each `snap_rd` strobe advances the index by one, and the strobe after word 4 returns it to word 0.
- R7: A snapshot command sets the read index back to word 0. If a read strobe arrives in the same cycle, the snapshot command takes precedence.
- R8: A command strobe with `cmd_snap` low, or `cmd_snap` high without `cmd_wr`, leaves both the snapshot contents and the read index unchanged.
- R9: Five `tw_wr` strobes load the time. Word 2 bits 2:0 give the seconds, word 3 gives nanoseconds bits 31:16, and word 4 gives nanoseconds bits 15:0. On the edge of the fifth strobe the time takes exactly the written value, with no increment applied in that cycle.
- R10: Word 0 and word 1 of a load sequence are ignored, and during the first four strobes the counter keeps advancing as in R2 to R4.
- R11: The load index returns to word 0 after the fifth strobe, so back-to-back load sequences each take effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 125 MHz time-base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inc_ns | input | INC_W | Signed per-cycle advance in nanoseconds |
| cmd_wr | input | 1 | Command register write strobe |
| cmd_snap | input | 1 | Snapshot bit of the command write |
| snap_rd | input | 1 | Snapshot data port read strobe |
| snap_data | output | 16 | Snapshot word at the current read index |
| tw_wr | input | 1 | Time-load port write strobe |
| tw_data | input | 16 | Time-load word |
| tod_ns | output | NS_W | Live nanoseconds field |
| tod_sec | output | 3 | Live seconds field (modulo 8) |

## Verification
The bench builds the block with NS_PER_SEC set to 70000 and INC_W set to 8. With those values a full second passes in under nine thousand cycles at the nominal increment, so a natural rollover from zero is observed cycle by cycle. The nanoseconds field is 17 bits wide, so word 3 of the snapshot carries a nonzero bit 16 and its slicing is tested. The bench sweeps every increment from -20 to +20 through plain advance. It also sweeps preloaded values near the top and bottom of the second to cover carries into the seconds field, borrows out of it, and exact hits on the limit.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam int WORD_W  = 16;
  localparam int SEC_W   = 3;
  localparam int WORDS   = 5;
  localparam int IDX_W   = $clog2(WORDS);
  localparam int FIELD_W = 32;

  typedef enum logic [IDX_W-1:0] {
    W_PAD0 = 3'd0,
    W_PAD1 = 3'd1,
    W_SEC  = 3'd2,
    W_NSHI = 3'd3,
    W_NSLO = 3'd4
  } word_e;

  function automatic word_e next_word(word_e cur);
    case (cur)
      W_PAD0:  return W_PAD1;
      W_PAD1:  return W_SEC;
      W_SEC:   return W_NSHI;
      W_NSHI:  return W_NSLO;
      default: return W_PAD0;
    endcase
  endfunction
endpackage

// File: rtl/tod_core.sv
module tod_core
  import tod_pkg::*;
#(
  parameter int NS_PER_SEC = 1_000_000_000,
  parameter int INC_W      = 8,
  parameter int NS_W       = 30
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic signed [INC_W-1:0] inc_i,
  input  logic                    ld_i,
  input  logic [NS_W-1:0]         ld_ns_i,
  input  logic [SEC_W-1:0]        ld_sec_i,
  output logic [NS_W-1:0]         ns_o,
  output logic [SEC_W-1:0]        sec_o
);
  localparam int SUM_W = ((NS_W > INC_W) ? NS_W : INC_W) + 2;
  localparam logic [SUM_W-1:0] LIM = SUM_W'(NS_PER_SEC);

  logic [NS_W-1:0]         ns_q, ns_d;
  logic [SEC_W-1:0]        sec_q, sec_d;
  logic signed [SUM_W-1:0] sum_s;
  logic [SUM_W-1:0]        sum_u;
  logic                    under, over;

  always_comb begin
    sum_s = $signed({{(SUM_W-NS_W){1'b0}}, ns_q}) + SUM_W'(inc_i);
    sum_u = sum_s;
    under = sum_s[SUM_W-1];
    over  = !under && (sum_u >= LIM);
    ns_d  = NS_W'(sum_u);
    sec_d = sec_q;
    if (ld_i) begin
      ns_d  = ld_ns_i;
      sec_d = ld_sec_i;
    end else if (under) begin
      ns_d  = NS_W'(sum_u + LIM);
      sec_d = SEC_W'(sec_q - 1'b1);
    end else if (over) begin
      ns_d  = NS_W'(sum_u - LIM);
      sec_d = SEC_W'(sec_q + 1'b1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ns_q  <= '0;
      sec_q <= '0;
    end else begin
      ns_q  <= ns_d;
      sec_q <= sec_d;
    end
  end

  assign ns_o  = ns_q;
  assign sec_o = sec_q;
endmodule

// File: rtl/tod_snap.sv
module tod_snap
  import tod_pkg::*;
#(
  parameter int NS_W = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_i,
  input  logic              adv_i,
  input  logic [NS_W-1:0]   ns_i,
  input  logic [SEC_W-1:0]  sec_i,
  output logic [WORD_W-1:0] word_o
);
  logic [NS_W-1:0]    hold_ns_q, hold_ns_d;
  logic [SEC_W-1:0]   hold_sec_q, hold_sec_d;
  word_e              idx_q, idx_d;
  logic               hold_en, idx_en;
  logic [FIELD_W-1:0] ns_wide;

  generate
    if (NS_W < FIELD_W) begin : g_pad
      assign ns_wide = {{(FIELD_W-NS_W){1'b0}}, hold_ns_q};
    end else begin : g_full
      assign ns_wide = hold_ns_q[FIELD_W-1:0];
    end
  endgenerate

  always_comb begin
    hold_en    = take_i;
    idx_en     = take_i || adv_i;
    hold_ns_d  = ns_i;
    hold_sec_d = sec_i;
    idx_d      = take_i ? W_PAD0 : next_word(idx_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_ns_q  <= '0;
      hold_sec_q <= '0;
    end else if (hold_en) begin
      hold_ns_q  <= hold_ns_d;
      hold_sec_q <= hold_sec_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= W_PAD0;
    else if (idx_en) idx_q <= idx_d;
  end

  always_comb begin
    case (idx_q)
      W_SEC:   word_o = WORD_W'(hold_sec_q);
      W_NSHI:  word_o = ns_wide[FIELD_W-1:WORD_W];
      W_NSLO:  word_o = ns_wide[WORD_W-1:0];
      default: word_o = '0;
    endcase
  end
endmodule

// File: rtl/tod_load.sv
module tod_load
  import tod_pkg::*;
#(
  parameter int NS_W = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [WORD_W-1:0] data_i,
  output logic              ld_o,
  output logic [NS_W-1:0]   ld_ns_o,
  output logic [SEC_W-1:0]  ld_sec_o
);
  word_e              idx_q;
  logic [SEC_W-1:0]   sec_q;
  logic [WORD_W-1:0]  hi_q;
  logic               sec_en, hi_en;
  logic [FIELD_W-1:0] full;

  always_comb begin
    sec_en = wr_i && (idx_q == W_SEC);
    hi_en  = wr_i && (idx_q == W_NSHI);
    ld_o   = wr_i && (idx_q == W_NSLO);
    full   = {hi_q, data_i};
  end

  generate
    if (NS_W < FIELD_W) begin : g_trunc
      assign ld_ns_o = full[NS_W-1:0];
    end else begin : g_wide
      assign ld_ns_o = NS_W'(full);
    end
  endgenerate

  assign ld_sec_o = sec_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    idx_q <= W_PAD0;
    else if (wr_i) idx_q <= next_word(idx_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sec_q <= '0;
    else if (sec_en) sec_q <= data_i[SEC_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     hi_q <= '0;
    else if (hi_en) hi_q <= data_i;
  end
endmodule

// File: rtl/tod_counter.sv
module tod_counter
  import tod_pkg::*;
#(
  parameter int NS_PER_SEC = 1_000_000_000,
  parameter int INC_W      = 8,
  localparam int NS_W      = $clog2(NS_PER_SEC)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic signed [INC_W-1:0] inc_ns,
  input  logic                    cmd_wr,
  input  logic                    cmd_snap,
  input  logic                    snap_rd,
  output logic [WORD_W-1:0]       snap_data,
  input  logic                    tw_wr,
  input  logic [WORD_W-1:0]       tw_data,
  output logic [NS_W-1:0]         tod_ns,
  output logic [SEC_W-1:0]        tod_sec
);
  logic             take;
  logic             ld;
  logic [NS_W-1:0]  ld_ns;
  logic [SEC_W-1:0] ld_sec;

  assign take = cmd_wr && cmd_snap;

  tod_load #(.NS_W(NS_W)) u_load (
    .clk(clk), .rst_n(rst_n), .wr_i(tw_wr), .data_i(tw_data),
    .ld_o(ld), .ld_ns_o(ld_ns), .ld_sec_o(ld_sec)
  );

  tod_core #(.NS_PER_SEC(NS_PER_SEC), .INC_W(INC_W), .NS_W(NS_W)) u_core (
    .clk(clk), .rst_n(rst_n), .inc_i(inc_ns), .ld_i(ld),
    .ld_ns_i(ld_ns), .ld_sec_i(ld_sec), .ns_o(tod_ns), .sec_o(tod_sec)
  );

  tod_snap #(.NS_W(NS_W)) u_snap (
    .clk(clk), .rst_n(rst_n), .take_i(take), .adv_i(snap_rd),
    .ns_i(tod_ns), .sec_i(tod_sec), .word_o(snap_data)
  );
endmodule

// File: rtl/tod_counter_chk.sv
module tod_counter_chk
  import tod_pkg::*;
#(
  parameter int NS_PER_SEC = 1_000_000_000,
  parameter int NS_W       = 30
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_wr,
  input logic              cmd_snap,
  input logic              snap_rd,
  input logic [WORD_W-1:0] snap_data,
  input logic              tw_wr,
  input logic [WORD_W-1:0] tw_data,
  input logic [NS_W-1:0]   tod_ns,
  input logic [SEC_W-1:0]  tod_sec
);
  logic [2:0]        wcnt_q;
  logic [SEC_W-1:0]  csec_q;
  logic [WORD_W-1:0] chi_q;
  logic              last_wr;

  assign last_wr = tw_wr && (wcnt_q == 3'd4);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcnt_q <= '0;
      csec_q <= '0;
      chi_q  <= '0;
    end else if (tw_wr) begin
      wcnt_q <= (wcnt_q == 3'd4) ? 3'd0 : wcnt_q + 3'd1;
      if (wcnt_q == 3'd2) csec_q <= tw_data[SEC_W-1:0];
      if (wcnt_q == 3'd3) chi_q  <= tw_data;
    end
  end

  // R3
  ns_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!last_wr && (32'(tod_ns) < NS_PER_SEC)) |=> (32'(tod_ns) < NS_PER_SEC));

  // R5
  snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!snap_rd && !(cmd_wr && cmd_snap)) |=> $stable(snap_data));

  // R7
  snap_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && cmd_snap) |=> (snap_data == '0));

  // R9
  load_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_wr |=> ((tod_ns == NS_W'({chi_q, $past(tw_data)})) && (tod_sec == csec_q)));
endmodule

bind tod_counter tod_counter_chk #(.NS_PER_SEC(NS_PER_SEC), .NS_W(NS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_snap(cmd_snap),
  .snap_rd(snap_rd), .snap_data(snap_data), .tw_wr(tw_wr), .tw_data(tw_data),
  .tod_ns(tod_ns), .tod_sec(tod_sec)
);

// File: tb/tod_counter_bench.sv
module tod_counter_bench;
  localparam int LIM   = 70000;
  localparam int INC_W = 8;
  localparam int NS_W  = $clog2(LIM);

  logic                    clk;
  logic                    rst_n;
  logic signed [INC_W-1:0] inc_ns;
  logic                    cmd_wr, cmd_snap, snap_rd, tw_wr;
  logic [15:0]             tw_data, snap_data;
  logic [NS_W-1:0]         tod_ns;
  logic [2:0]              tod_sec;

  int checks = 0;
  int fails  = 0;
  int m_ns, m_sec, s_ns, s_sec, ridx, widx, w_sec, w_hi;

  tod_counter #(.NS_PER_SEC(LIM), .INC_W(INC_W)) u_tod_counter (
    .clk(clk), .rst_n(rst_n), .inc_ns(inc_ns), .cmd_wr(cmd_wr),
    .cmd_snap(cmd_snap), .snap_rd(snap_rd), .snap_data(snap_data),
    .tw_wr(tw_wr), .tw_data(tw_data), .tod_ns(tod_ns), .tod_sec(tod_sec)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int exp_word(int i);
    case (i)
      2:       return s_sec;
      3:       return (s_ns >> 16) & 16'hffff;
      4:       return s_ns & 16'hffff;
      default: return 0;
    endcase
  endfunction

  // One cycle: called at a negedge, returns at the next negedge.
  task automatic step(string tag, int inc, bit cw, bit cs, bit rd, bit wr, int wd);
    int n;
    bit load;
    chk(tag, "snap_data", int'(snap_data), exp_word(ridx));
    inc_ns = INC_W'(inc); cmd_wr = cw; cmd_snap = cs; snap_rd = rd;
    tw_wr = wr; tw_data = 16'(wd);
    load = 1'b0;
    if (cw && cs) begin s_ns = m_ns; s_sec = m_sec; ridx = 0; end
    else if (rd) ridx = (ridx + 1) % 5;
    if (wr) begin
      if (widx == 2) w_sec = wd & 7;
      if (widx == 3) w_hi = wd & 16'hffff;
      if (widx == 4) load = 1'b1;
      widx = (widx + 1) % 5;
    end
    if (load) begin
      m_ns = ((w_hi << 16) | (wd & 16'hffff)) % (1 << NS_W);
      m_sec = w_sec;
    end else begin
      n = m_ns + inc;
      if (n >= LIM) begin n -= LIM; m_sec = (m_sec + 1) % 8; end
      else if (n < 0) begin n += LIM; m_sec = (m_sec + 7) % 8; end
      m_ns = n;
    end
    @(negedge clk);
    cmd_wr = 0; cmd_snap = 0; snap_rd = 0; tw_wr = 0;
    chk(tag, "tod_ns", int'(tod_ns), m_ns);
    chk(tag, "tod_sec", int'(tod_sec), m_sec);
  endtask

  task automatic run(string tag, int inc, int n);
    for (int i = 0; i < n; i++) step(tag, inc, 0, 0, 0, 0, 0);
  endtask

  task automatic load_time(string tag, int inc, int sec, int ns);
    step(tag, inc, 0, 0, 0, 1, 16'h5a5a);
    step(tag, inc, 0, 0, 0, 1, 16'hffff);
    step(tag, inc, 0, 0, 0, 1, sec | 16'h0010);
    step(tag, inc, 0, 0, 0, 1, ns >> 16);
    step(tag, inc, 0, 0, 0, 1, ns & 16'hffff);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 0; inc_ns = 0; cmd_wr = 0; cmd_snap = 0; snap_rd = 0;
    tw_wr = 0; tw_data = 0;
    m_ns = 0; m_sec = 0; s_ns = 0; s_sec = 0; ridx = 0; widx = 0; w_sec = 0; w_hi = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state and an all-zero snapshot walk
    chk("R1", "tod_ns", int'(tod_ns), 0);
    chk("R1", "tod_sec", int'(tod_sec), 0);
    for (int i = 0; i < 6; i++) step("R1", 0, 0, 0, 1, 0, 0);
    // R2: increment sweep, R10 covered by advancing during loads
    load_time("R10", 8, 3, 30000);
    for (int inc = -20; inc <= 20; inc++) run("R2", inc, 3);
    // R3: carry near the top of the second, including exact hits
    for (int k = 1; k <= 12; k++) begin
      for (int j = 0; j < 4; j++) begin
        int incs[4] = '{1, 5, 8, 13};
        load_time("R9", 0, (k + 5) % 8, LIM - k);
        run("R3", incs[j], 4);
      end
    end
    // R4: borrow below zero
    for (int k = 0; k <= 10; k++) begin
      for (int j = 0; j < 3; j++) begin
        int incs[3] = '{-1, -7, -8};
        load_time("R9", 0, k % 8, k);
        run("R4", incs[j], 3);
      end
    end
    // R3: natural rollover from zero at nominal rate
    load_time("R9", 8, 7, 0);
    run("R3", 8, 8760);
    // R5/R6: snapshot with bit 16 set, then read all words and wrap
    load_time("R9", 8, 5, 69800);
    step("R5", 8, 1, 1, 0, 0, 0);
    run("R5", 8, 10);
    for (int i = 0; i < 6; i++) step("R6", 8, 0, 0, 1, 0, 0);
    // R7: restart mid-read, and snapshot wins over a read strobe
    step("R7", 8, 0, 0, 1, 0, 0);
    step("R7", 8, 0, 0, 1, 0, 0);
    step("R7", 8, 1, 1, 0, 0, 0);
    step("R7", 8, 0, 0, 1, 0, 0);
    step("R7", 8, 1, 1, 1, 0, 0);
    for (int i = 0; i < 5; i++) step("R7", 8, 0, 0, 1, 0, 0);
    // R8: incomplete commands leave the snapshot and index alone
    step("R8", 8, 0, 0, 1, 0, 0);
    step("R8", 8, 1, 0, 0, 0, 0);
    step("R8", 8, 0, 1, 0, 0, 0);
    for (int i = 0; i < 5; i++) step("R8", 8, 0, 0, 1, 0, 0);
    // R11: back-to-back load sequences
    load_time("R11", 8, 2, 1234);
    load_time("R11", 8, 6, 65536 + 77);
    run("R11", 8, 4);
    step("R6", 8, 1, 1, 0, 0, 0);
    for (int i = 0; i < 5; i++) step("R6", 8, 0, 0, 1, 0, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule